// File: doc/BRIEF.md
# Trigger Tower History Capture Buffer

This block sits at the front of a calorimeter trigger readout path. Every beam crossing it takes in one 16-bit word per trigger tower. Each word is made of an 8-bit electromagnetic transverse-energy byte and an 8-bit total transverse-energy byte. The two bytes reach the block one after the other on a shared byte bus, and a select line says which half each byte is. Bytes are latched on the falling edge of a tower strobe. Each completed crossing is stored in a ring of crossing slots, which acts as a history shift register of `DEPTH` stages.

The level-1 accept arrives several crossings after the crossing it refers to. The capture strobe therefore picks the stored crossing whose age equals a programmable latency. It copies that crossing into a separate readout buffer. In two-tick mode it copies the crossing before it as well. The history keeps filling while the snapshot is sent. The record leaves as one 16-bit word per rising edge of a transmit strobe, in tower order, with a valid flag and an end-of-record flag on the last word.

Both strobes are sampled levels that are synchronous to the system clock `clk`. The tower count, the history depth and the byte width are parameters.

Top module: `tth_history_capture`

## Requirements
- R1: A byte on `twr_byte` is taken in only in the first clock cycle in which `twr_clk` is seen low after being high. Values present while `twr_clk` is high are never stored.
- R2: A byte taken in with `em_sel`=1 is held as the EM half. A byte taken in with `em_sel`=0 completes the current tower word {EM half in bits 15:8, total byte in bits 7:0}. Towers are numbered from 0 in arrival order. After `N_TWR` completed words the crossing closes and the history advances by one crossing.
- R3: On a capture in single-tick mode, the effective latency is `lat_cfg` clamped to the range 1 to `DEPTH`-1. The captured crossing is the one that closed that many crossings before the crossing now being received.
- R4: With `two_tick`=1, the effective latency is clamped to the range 1 to `DEPTH`-2. The record holds the crossing one older than the triggered crossing, followed by the triggered crossing.
- R5: Each rising edge of `xmit_clk` during a readout produces exactly one word, with `rd_vld` high for one cycle. Words go out in tower order 0 to `N_TWR`-1 within each crossing.
- R6: `rd_eor` is high together with `rd_vld` on the last word of a record only. That is word `N_TWR` in single-tick mode and word 2·`N_TWR` in two-tick mode.
- R7: Crossings that keep arriving after a capture do not alter the record being sent.
- R8: A capture while a record is being copied or sent is ignored: it adds no words to the output. It also sets `ovr_flag`, which stays set until reset.
- R9: After reset, `rd_vld`, `rd_eor` and `ovr_flag` are low, and no word is sent until a capture is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| twr_clk | input | 1 | Tower strobe level; bytes are taken on its falling edge |
| em_sel | input | 1 | 1 = byte is EM energy, 0 = byte is total energy |
| twr_byte | input | BYTE_W | Interleaved tower energy byte |
| acc_cap | input | 1 | Capture strobe (one cycle per accept) |
| two_tick | input | 1 | Read out two consecutive crossings |
| lat_cfg | input | LAT_W | Accept latency in crossings |
| xmit_clk | input | 1 | Transmit strobe level; one word per rising edge |
| rd_word | output | 2*BYTE_W | Output tower word |
| rd_vld | output | 1 | `rd_word` holds a new word this cycle |
| rd_eor | output | 1 | Last word of the record |
| ovr_flag | output | 1 | Sticky: a capture arrived during a readout |

## Verification
The assertions assume that `twr_clk` and `xmit_clk` change only between clock edges and hold each level for at least one full clock. Under that assumption, two edges of either strobe are never in adjacent cycles. They also assume `em_sel` is settled in the cycle the tower strobe falls. The bench drives every strobe phase for one whole cycle from the falling clock edge and toggles `xmit_clk` every two cycles. It fills the history with more than `DEPTH` crossings before the first capture, so every latency it asks for points at data it has written.

// File: rtl/tth_pkg.sv
package tth_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_SEND = 2'd2
  } snap_st_e;

  // Slot index 'back' steps behind 'cur' on a ring of 'depth' slots.
  function automatic int ring_back(input int cur, input int back, input int depth);
    return (cur >= back) ? (cur - back) : (cur + depth - back);
  endfunction

endpackage

// File: rtl/tth_sdp_ram.sv
module tth_sdp_ram #(
  parameter int W = 16,
  parameter int D = 256,
  localparam int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rq
);

  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end

endmodule

// File: rtl/tth_ingest.sv
module tth_ingest #(
  parameter int N_TWR  = 128,
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  localparam int TWR_W  = $clog2(N_TWR),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int AW     = $clog2(N_TWR * DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                twr_clk,
  input  logic                em_sel,
  input  logic [BYTE_W-1:0]   twr_byte,
  output logic                hw_en,
  output logic [AW-1:0]       hw_addr,
  output logic [2*BYTE_W-1:0] hw_data,
  output logic [SLOT_W-1:0]   cur_slot
);

  logic              clk_q;
  logic              fall;
  logic [BYTE_W-1:0] em_hold;
  logic [TWR_W-1:0]  twr_idx;

  assign fall = clk_q & ~twr_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q    <= 1'b0;
      em_hold  <= '0;
      twr_idx  <= '0;
      cur_slot <= '0;
      hw_en    <= 1'b0;
      hw_addr  <= '0;
      hw_data  <= '0;
    end else begin
      clk_q <= twr_clk;
      hw_en <= 1'b0;
      if (fall) begin
        if (em_sel) begin
          em_hold <= twr_byte;
        end else begin
          hw_en   <= 1'b1;
          hw_addr <= AW'(cur_slot) * AW'(N_TWR) + AW'(twr_idx);
          hw_data <= {em_hold, twr_byte};
          if (twr_idx == TWR_W'(N_TWR - 1)) begin
            twr_idx  <= '0;
            cur_slot <= (cur_slot == SLOT_W'(DEPTH - 1)) ? '0 : cur_slot + 1'b1;
          end else begin
            twr_idx <= twr_idx + 1'b1;
          end
        end
      end
    end
  end

  // A history write follows only a high-to-low strobe step with the total half selected.
  AST_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    hw_en |-> ($past(twr_clk, 2) && !$past(twr_clk, 1) && !$past(em_sel, 1))); // R1

endmodule

// File: rtl/tth_snapshot.sv
module tth_snapshot
  import tth_pkg::*;
#(
  parameter int N_TWR  = 128,
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int LAT_W  = $clog2(DEPTH) + 1,
  localparam int AW     = $clog2(N_TWR * DEPTH),
  localparam int TWR_W  = $clog2(N_TWR),
  localparam int BUF_D  = 2 * N_TWR,
  localparam int BUF_AW = $clog2(2 * N_TWR),
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              two_tick,
  input  logic [LAT_W-1:0]  lat_cfg,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic              xmit_clk,
  output logic              hr_en,
  output logic [AW-1:0]     hr_addr,
  input  logic [WORD_W-1:0] hr_q,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_vld,
  output logic              rd_eor,
  output logic              ovr_flag
);

  snap_st_e          st;
  logic [LAT_W-1:0]  lat_lim;
  logic [LAT_W-1:0]  lat_eff;
  logic [SLOT_W-1:0] src_slot;

  logic [SLOT_W-1:0] cp_slot;
  logic [TWR_W-1:0]  cp_twr;
  logic [BUF_AW-1:0] cp_cnt;
  logic [BUF_AW-1:0] rec_last;
  logic              bw_en;
  logic [BUF_AW-1:0] bw_addr;

  logic              xq;
  logic              xe;
  logic              br_en;
  logic [BUF_AW-1:0] snd_idx;
  logic              snd_pend;
  logic              snd_last;
  logic [WORD_W-1:0] buf_q;

  // Latency clamp and source slot selection
  always_comb begin
    lat_lim = two_tick ? LAT_W'(DEPTH - 2) : LAT_W'(DEPTH - 1);
    if (lat_cfg == '0)          lat_eff = LAT_W'(1);
    else if (lat_cfg > lat_lim) lat_eff = lat_lim;
    else                        lat_eff = lat_cfg;
    src_slot = SLOT_W'(ring_back(int'(cur_slot), int'(lat_eff) + int'(two_tick), DEPTH));
  end

  assign hr_en   = (st == ST_COPY);
  assign hr_addr = AW'(cp_slot) * AW'(N_TWR) + AW'(cp_twr);
  assign xe      = xmit_clk & ~xq;
  assign br_en   = (st == ST_SEND) && xe;

  tth_sdp_ram #(.W(WORD_W), .D(BUF_D)) buf_ram_i (
    .clk (clk),
    .we  (bw_en),
    .wa  (bw_addr),
    .wd  (hr_q),
    .re  (br_en),
    .ra  (snd_idx),
    .rq  (buf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cp_slot  <= '0;
      cp_twr   <= '0;
      cp_cnt   <= '0;
      rec_last <= '0;
      bw_en    <= 1'b0;
      bw_addr  <= '0;
      xq       <= 1'b0;
      snd_idx  <= '0;
      snd_pend <= 1'b0;
      snd_last <= 1'b0;
      rd_word  <= '0;
      rd_vld   <= 1'b0;
      rd_eor   <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      xq       <= xmit_clk;
      bw_en    <= 1'b0;
      snd_pend <= 1'b0;
      rd_vld   <= snd_pend;
      rd_eor   <= snd_pend & snd_last;
      if (snd_pend) rd_word <= buf_q;

      if (cap && st != ST_IDLE) ovr_flag <= 1'b1;

      case (st)
        ST_IDLE: begin
          if (cap) begin
            st       <= ST_COPY;
            cp_slot  <= src_slot;
            cp_twr   <= '0;
            cp_cnt   <= '0;
            snd_idx  <= '0;
            rec_last <= two_tick ? BUF_AW'(2 * N_TWR - 1) : BUF_AW'(N_TWR - 1);
          end
        end
        ST_COPY: begin
          bw_en   <= 1'b1;
          bw_addr <= cp_cnt;
          cp_cnt  <= cp_cnt + 1'b1;
          if (cp_twr == TWR_W'(N_TWR - 1)) begin
            cp_twr  <= '0;
            cp_slot <= (cp_slot == SLOT_W'(DEPTH - 1)) ? '0 : cp_slot + 1'b1;
          end else begin
            cp_twr <= cp_twr + 1'b1;
          end
          if (cp_cnt == rec_last) st <= ST_SEND;
        end
        ST_SEND: begin
          if (xe) begin
            snd_pend <= 1'b1;
            snd_last <= (snd_idx == rec_last);
            snd_idx  <= snd_idx + 1'b1;
            if (snd_idx == rec_last) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_EOR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_eor |-> rd_vld); // R6

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_vld |=> !rd_vld); // R5

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr_flag |=> ovr_flag); // R8

  AST_LAT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && cap && !two_tick) |-> (lat_eff >= LAT_W'(1) && lat_eff <= LAT_W'(DEPTH - 1))); // R3

  AST_PAIR_LAT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && cap && two_tick) |-> (lat_eff >= LAT_W'(1) && lat_eff <= LAT_W'(DEPTH - 2))); // R4

  AST_NO_WORD_IN_COPY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COPY) |-> !snd_pend); // R7

endmodule

// File: rtl/tth_history_capture.sv
module tth_history_capture #(
  parameter int N_TWR  = 128,
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  localparam int LAT_W = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                twr_clk,
  input  logic                em_sel,
  input  logic [BYTE_W-1:0]   twr_byte,
  input  logic                acc_cap,
  input  logic                two_tick,
  input  logic [LAT_W-1:0]    lat_cfg,
  input  logic                xmit_clk,
  output logic [2*BYTE_W-1:0] rd_word,
  output logic                rd_vld,
  output logic                rd_eor,
  output logic                ovr_flag
);

  localparam int SLOT_W = $clog2(DEPTH);
  localparam int AW     = $clog2(N_TWR * DEPTH);
  localparam int WORD_W = 2 * BYTE_W;

  logic              hw_en;
  logic [AW-1:0]     hw_addr;
  logic [WORD_W-1:0] hw_data;
  logic [SLOT_W-1:0] cur_slot;
  logic              hr_en;
  logic [AW-1:0]     hr_addr;
  logic [WORD_W-1:0] hr_q;

  tth_ingest #(.N_TWR(N_TWR), .DEPTH(DEPTH), .BYTE_W(BYTE_W)) ingest_i (
    .clk      (clk),
    .rst      (rst),
    .twr_clk  (twr_clk),
    .em_sel   (em_sel),
    .twr_byte (twr_byte),
    .hw_en    (hw_en),
    .hw_addr  (hw_addr),
    .hw_data  (hw_data),
    .cur_slot (cur_slot)
  );

  tth_sdp_ram #(.W(WORD_W), .D(N_TWR * DEPTH)) hist_ram_i (
    .clk (clk),
    .we  (hw_en),
    .wa  (hw_addr),
    .wd  (hw_data),
    .re  (hr_en),
    .ra  (hr_addr),
    .rq  (hr_q)
  );

  tth_snapshot #(.N_TWR(N_TWR), .DEPTH(DEPTH), .BYTE_W(BYTE_W)) snap_i (
    .clk      (clk),
    .rst      (rst),
    .cap      (acc_cap),
    .two_tick (two_tick),
    .lat_cfg  (lat_cfg),
    .cur_slot (cur_slot),
    .xmit_clk (xmit_clk),
    .hr_en    (hr_en),
    .hr_addr  (hr_addr),
    .hr_q     (hr_q),
    .rd_word  (rd_word),
    .rd_vld   (rd_vld),
    .rd_eor   (rd_eor),
    .ovr_flag (ovr_flag)
  );

endmodule

// File: tb/tth_history_capture_tb.sv
module tth_history_capture_tb_top;

  localparam int N     = 8;
  localparam int D     = 8;
  localparam int LAT_W = $clog2(D) + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             twr_clk = 1'b0;
  logic             em_sel = 1'b0;
  logic [7:0]       twr_byte = '0;
  logic             acc_cap = 1'b0;
  logic             two_tick = 1'b0;
  logic [LAT_W-1:0] lat_cfg = '0;
  logic             xmit_clk = 1'b0;
  logic [15:0]      rd_word;
  logic             rd_vld;
  logic             rd_eor;
  logic             ovr_flag;

  int checks = 0;
  int fails  = 0;
  int xcnt   = 0;
  int n      = 0;
  logic [15:0] got_w [64];
  logic        got_e [64];

  tth_history_capture #(.N_TWR(N), .DEPTH(D), .BYTE_W(8)) dut_i (
    .clk(clk), .rst(rst), .twr_clk(twr_clk), .em_sel(em_sel), .twr_byte(twr_byte),
    .acc_cap(acc_cap), .two_tick(two_tick), .lat_cfg(lat_cfg), .xmit_clk(xmit_clk),
    .rd_word(rd_word), .rd_vld(rd_vld), .rd_eor(rd_eor), .ovr_flag(ovr_flag)
  );

  always #4 clk = ~clk;

  // free-running transmit strobe, two cycles per level
  initial forever begin
    repeat (2) @(negedge clk);
    xmit_clk = ~xmit_clk;
  end

  // output collector
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      if (n < 64) begin
        got_w[n] = rd_word;
        got_e[n] = rd_eor;
      end
      n = n + 1;
    end
  end

  // {lat_cfg[3:0], two_tick, expected age of first crossing[3:0], crossings[1:0]}
  localparam logic [10:0] VECS [8] = '{
    {4'd3,  1'b0, 4'd3, 2'd1},
    {4'd1,  1'b0, 4'd1, 2'd1},
    {4'd0,  1'b0, 4'd1, 2'd1},
    {4'd7,  1'b0, 4'd7, 2'd1},
    {4'd12, 1'b0, 4'd7, 2'd1},
    {4'd2,  1'b1, 4'd3, 2'd2},
    {4'd7,  1'b1, 4'd7, 2'd2},
    {4'd0,  1'b1, 4'd2, 2'd2}
  };

  function automatic logic [7:0] em_of(input int x, input int t);
    return 8'(x * 13 + t * 3 + 5);
  endfunction

  function automatic logic [7:0] tot_of(input int x, input int t);
    return 8'(x * 7 + t * 11 + 200);
  endfunction

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // byte held as its complement while the strobe is high, true value on the low phase (R1)
  task automatic put_byte(input logic sel, input logic [7:0] b);
    @(negedge clk); twr_clk = 1'b1; em_sel = sel; twr_byte = ~b;
    @(negedge clk); twr_clk = 1'b0; twr_byte = b;
  endtask

  task automatic feed_xing();
    for (int t = 0; t < N; t++) begin
      put_byte(1'b1, em_of(xcnt, t));
      put_byte(1'b0, tot_of(xcnt, t));
    end
    xcnt++;
  endtask

  task automatic do_cap(input logic [LAT_W-1:0] l, input logic tt);
    @(negedge clk); acc_cap = 1'b1; lat_cfg = l; two_tick = tt;
    @(negedge clk); acc_cap = 1'b0;
  endtask

  // R1 R2 word content, R5 count and order, R6 end flag, R7 snapshot integrity
  task automatic check_rec(input int first_x, input int nx, input string tag);
    check({tag, " word count (R5)"}, n == nx * N, n, nx * N);
    for (int k = 0; k < nx; k++) begin
      for (int t = 0; t < N; t++) begin
        int idx;
        logic [15:0] ew;
        logic ee;
        idx = k * N + t;
        ew = {em_of(first_x + k, t), tot_of(first_x + k, t)};
        ee = (idx == nx * N - 1);
        if (idx < n && idx < 64)
          check({tag, " word R1 R2 R6 R7"}, got_w[idx] === ew && got_e[idx] === ee,
                {got_e[idx], got_w[idx]}, {ee, ew});
        else
          check({tag, " word missing R5"}, 1'b0, idx, nx * N);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 rd_vld after reset", rd_vld == 1'b0, rd_vld, 0);
    check("R9 rd_eor after reset", rd_eor == 1'b0, rd_eor, 0);
    check("R9 ovr_flag after reset", ovr_flag == 1'b0, ovr_flag, 0);
    n = 0;
    repeat (40) @(negedge clk);
    check("R9 no words before capture", n == 0, n, 0);

    for (int i = 0; i < D + 2; i++) feed_xing();

    // table walk: R3 single-tick, R4 two-tick
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      int first;
      v = VECS[i];
      feed_xing();
      n = 0;
      first = xcnt - int'(v[5:2]);
      do_cap(v[10:7], v[6]);
      for (int j = 0; j < 3; j++) feed_xing();  // history keeps moving (R7)
      repeat (30) @(negedge clk);
      check_rec(first, int'(v[1:0]), v[6] ? "R4" : "R3");
    end
    check("R8 no overrun in clean runs", ovr_flag == 1'b0, ovr_flag, 0);

    // R8 capture during readout is ignored and sets the sticky flag
    feed_xing();
    n = 0;
    begin
      int first;
      first = xcnt - 2;
      do_cap(4'd2, 1'b0);
      repeat (3) @(negedge clk);
      do_cap(4'd5, 1'b1);
      for (int j = 0; j < 3; j++) feed_xing();
      repeat (30) @(negedge clk);
      check_rec(first, 1, "R8");
    end
    check("R8 overrun flag set", ovr_flag == 1'b1, ovr_flag, 1);
    repeat (50) @(negedge clk);
    check("R8 overrun flag sticky", ovr_flag == 1'b1, ovr_flag, 1);

    // R9 reset clears the flag and the output stays quiet
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    n = 0;
    @(negedge clk);
    check("R9 ovr_flag cleared by reset", ovr_flag == 1'b0, ovr_flag, 0);
    repeat (40) @(negedge clk);
    check("R9 quiet after reset", n == 0 && rd_vld == 1'b0, n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule